// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block is the front end and sequencer of one DMA channel that moves one data unit for each accepted request. Software arms the channel with a single configuration write strobe. That write carries the source address, the destination address, the unit count, the two increment enables and the level-activation bit. From the clock edge after that write, the block watches an active-low request pin. It samples the pin on every rising edge for as long as the acceptance window is open.

A low level seen while the window is open is latched as a held request, and the window closes. The held request is consumed at the first edge where the bus-free indication is high. That edge starts the activation: the block spends a programmable number of break cycles and then runs one read at the source address and one write of the read data at the destination address. Each bus cycle advances only on an acknowledge. The window re-opens at the edge that completes the write. After the last unit the channel shuts itself off and raises its done flag.

Top module: `dreq_level_seq`

## Requirements
- R1: An accepted configuration write (`cfg_we` high while `busy` is low) loads all configuration inputs at that clock edge and opens the acceptance window. The pin is not sampled at that edge, so a low level present only during the write cycle starts no transfer.
- R2: While the window is open, the channel is enabled and `cfg_level` is 1, `req_n` is sampled at every rising edge. A low level lasting exactly one edge is captured and yields exactly one read/write pair.
- R3: From the edge that captures a request until the edge that completes its write, the window is closed. Low levels on `req_n` in that interval start no further transfer.
- R4: A held request keeps `busy` high and waits without any bus cycle while `bus_free` is low. The first edge with `bus_free` high starts the activation, and the read becomes visible GAP-1 edges after that edge. A read therefore starts no earlier than GAP (at least 2) edges after the capturing edge.
- R5: Each activation performs one read (`m_valid`=1, `m_write`=0, `m_addr` = source address) followed directly by one write (`m_write`=1, `m_addr` = destination address, `m_wdata` = data returned on the read). Each cycle holds its address and type until the edge where `m_ack` is high.
- R6: The window re-opens at the edge that completes the write. With `req_n` held low, `bus_free` high and `m_ack` returned in the first cycle, the next read becomes visible exactly GAP+1 edges after that completion edge. Exactly one pair occurs per window.
- R7: With `cfg_level` loaded as 0, the request pin has no effect and no bus cycle occurs.
- R8: The unit count decrements on every completed write. The edge that completes the last unit sets `done` to 1 and disables the channel, after which `req_n` starts nothing. `done` is cleared by the next accepted configuration write that enables with a non-zero count or disables.
- R9: An accepted enabling write with a count of 0 sets `done` at that edge and starts no bus cycle.
- R10: After each completed unit, the source and destination addresses each advance by DW/8 when their own increment bit was loaded as 1, and otherwise stay unchanged.
- R11: While `busy` is high, `cfg_we` is ignored and the running transfer continues unchanged.
- R12: In reset, `m_valid`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Channel enable value carried by the write |
| cfg_level | input | 1 | Level-activation bit for the request pin |
| cfg_src_inc | input | 1 | Advance source address after each unit |
| cfg_dst_inc | input | 1 | Advance destination address after each unit |
| cfg_src | input | AW | Initial source address |
| cfg_dst | input | AW | Initial destination address |
| cfg_count | input | CW | Number of units to move |
| req_n | input | 1 | External request pin, active low |
| bus_free | input | 1 | Bus may be taken this cycle |
| m_valid | output | 1 | Bus cycle in progress |
| m_write | output | 1 | 1 = write cycle, 0 = read cycle |
| m_addr | output | AW | Bus address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, taken when `m_ack` is high |
| m_ack | input | 1 | Bus cycle acknowledge |
| busy | output | 1 | Request held or activation running |
| done | output | 1 | Programmed count exhausted |

## Verification
The bench builds the block with 16-bit addresses and data, an 8-bit count and GAP = 3. With GAP above 2, the counted break-window variant is elaborated and the exact read-start offsets of R4 and R6 can be told apart from the 2-cycle minimum. A 2-byte step makes each address advance visible in the low address bits. With an 8-bit count, randomized runs of several units reach the last-unit shutdown in every round while backpressure and bus-busy gaps shift each handshake.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_BREAK = 2'd1,
      SEQ_READ  = 2'd2,
      SEQ_WRITE = 2'd3
   } seq_state_e;

   localparam int unsigned PORT_SRC = 0;
   localparam int unsigned PORT_DST = 1;
   localparam int unsigned N_PORTS  = 2;

endpackage

// File: rtl/dreq_accept.sv
// Acceptance window and held-request latch for the request pin.
module dreq_accept (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,        // open the window; pin ignored on this edge
   input  logic clear_i,      // close window and drop any held request
   input  logic sample_en_i,  // channel enabled and level activation on
   input  logic req_n_i,
   input  logic take_i,       // activation consumes the held request
   output logic held_o,
   output logic open_o
);

   logic open_q;
   logic held_q;
   logic hit;

   assign hit = open_q && sample_en_i && !req_n_i && !arm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         held_q <= 1'b0;
      end else if (clear_i) begin
         open_q <= 1'b0;
         held_q <= 1'b0;
      end else begin
         if (arm_i) begin
            open_q <= 1'b1;
         end else if (hit) begin
            open_q <= 1'b0;
         end
         if (take_i) begin
            held_q <= 1'b0;
         end else if (hit) begin
            held_q <= 1'b1;
         end
      end
   end

   assign held_o = held_q;
   assign open_o = open_q;

endmodule

// File: rtl/dreq_addr_step.sv
// One address register with its own increment enable.
module dreq_addr_step #(
   parameter int unsigned AW   = 16,
   parameter int unsigned STEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_addr_i,
   input  logic          load_inc_i,
   input  logic          adv_i,
   output logic [AW-1:0] addr_o
);

   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic [AW-1:0] addr_q;
   logic          inc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         inc_q  <= 1'b0;
      end else if (load_i) begin
         addr_q <= load_addr_i;
         inc_q  <= load_inc_i;
      end else if (adv_i && inc_q) begin
         addr_q <= addr_q + STEP_V;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/dreq_seq_ctrl.sv
// Activation sequencer: break window, read, write, unit count, done.
module dreq_seq_ctrl
   import dreq_pkg::*;
#(
   parameter int unsigned CW  = 8,
   parameter int unsigned DW  = 16,
   parameter int unsigned GAP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we_i,
   input  logic          cfg_en_i,
   input  logic [CW-1:0] cfg_count_i,
   input  logic          held_i,
   input  logic          bus_free_i,
   input  logic          m_ack_i,
   input  logic [DW-1:0] m_rdata_i,
   output seq_state_e    state_o,
   output logic          chan_en_o,
   output logic          done_o,
   output logic          busy_o,
   output logic          cfg_load_o,
   output logic          arm_o,
   output logic          clear_o,
   output logic          take_o,
   output logic          adv_o,
   output logic [DW-1:0] data_o
);

   localparam int unsigned   GW    = (GAP > 2) ? $clog2(GAP) : 1;
   localparam logic [CW-1:0] ONE_C = CW'(1);

   seq_state_e    state_q, state_d;
   logic [CW-1:0] count_q;
   logic          chan_q;
   logic          done_q;
   logic [DW-1:0] data_q;

   logic cfg_load;
   logic cfg_start;
   logic take;
   logic rd_done;
   logic wr_done;
   logic last_unit;
   logic brk_done;

   assign busy_o    = held_i || (state_q != SEQ_IDLE);
   assign cfg_load  = cfg_we_i && !busy_o;
   assign cfg_start = cfg_load && cfg_en_i && (cfg_count_i != '0);
   assign take      = (state_q == SEQ_IDLE) && held_i && bus_free_i && chan_q;
   assign rd_done   = (state_q == SEQ_READ)  && m_ack_i;
   assign wr_done   = (state_q == SEQ_WRITE) && m_ack_i;
   assign last_unit = (count_q == ONE_C);

   // Break window length: direct for the 2-cycle minimum, counted above it.
   generate
      if (GAP == 2) begin : g_gap_direct
         assign brk_done = 1'b1;
      end else begin : g_gap_count
         logic [GW-1:0] gcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gcnt_q <= '0;
            end else if (take) begin
               gcnt_q <= GW'(GAP - 2);
            end else if ((state_q == SEQ_BREAK) && (gcnt_q != '0)) begin
               gcnt_q <= gcnt_q - 1'b1;
            end
         end
         assign brk_done = (gcnt_q == '0);
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:  if (take)     state_d = SEQ_BREAK;
         SEQ_BREAK: if (brk_done) state_d = SEQ_READ;
         SEQ_READ:  if (m_ack_i)  state_d = SEQ_WRITE;
         SEQ_WRITE: if (m_ack_i)  state_d = SEQ_IDLE;
         default:                 state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         chan_q  <= 1'b0;
         done_q  <= 1'b0;
      end else if (cfg_load) begin
         count_q <= cfg_count_i;
         chan_q  <= cfg_start;
         done_q  <= cfg_en_i && (cfg_count_i == '0);
      end else if (wr_done) begin
         count_q <= count_q - ONE_C;
         if (last_unit) begin
            chan_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_done) begin
         data_q <= m_rdata_i;
      end
   end

   assign state_o    = state_q;
   assign chan_en_o  = chan_q;
   assign done_o     = done_q;
   assign cfg_load_o = cfg_load;
   assign arm_o      = cfg_start || (wr_done && !last_unit);
   assign clear_o    = cfg_load && !cfg_start;
   assign take_o     = take;
   assign adv_o      = wr_done;
   assign data_o     = data_q;

endmodule

// File: rtl/dreq_level_seq.sv
// Single-channel level-requested DMA sequencer, normal (one unit) mode.
module dreq_level_seq
   import dreq_pkg::*;
#(
   parameter int unsigned AW  = 16,
   parameter int unsigned DW  = 16,
   parameter int unsigned CW  = 8,
   parameter int unsigned GAP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_en,
   input  logic          cfg_level,
   input  logic          cfg_src_inc,
   input  logic          cfg_dst_inc,
   input  logic [AW-1:0] cfg_src,
   input  logic [AW-1:0] cfg_dst,
   input  logic [CW-1:0] cfg_count,
   input  logic          req_n,
   input  logic          bus_free,
   output logic          m_valid,
   output logic          m_write,
   output logic [AW-1:0] m_addr,
   output logic [DW-1:0] m_wdata,
   input  logic [DW-1:0] m_rdata,
   input  logic          m_ack,
   output logic          busy,
   output logic          done
);

   localparam int unsigned STEP = DW / 8;

   // Elaboration-time parameter checks.
   generate
      if (GAP < 2) begin : g_bad_gap
         $error("dreq_level_seq: GAP must be at least 2");
      end
      if ((DW % 8) != 0 || DW == 0) begin : g_bad_dw
         $error("dreq_level_seq: DW must be a non-zero multiple of 8");
      end
      if (CW < 1) begin : g_bad_cw
         $error("dreq_level_seq: CW must be at least 1");
      end
      if (AW < 2) begin : g_bad_aw
         $error("dreq_level_seq: AW must be at least 2");
      end
   endgenerate

   seq_state_e state;
   logic       chan_en;
   logic       cfg_load;
   logic       arm;
   logic       clear;
   logic       take;
   logic       adv;
   logic       held;
   logic       win_open;
   logic       level_q;
   logic       sample_en;
   logic [DW-1:0] data;

   logic [N_PORTS-1:0][AW-1:0] base_addr;
   logic [N_PORTS-1:0]         base_inc;
   logic [N_PORTS-1:0][AW-1:0] cur_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
      end else if (cfg_load) begin
         level_q <= cfg_level;
      end
   end

   assign sample_en = chan_en && level_q;

   dreq_accept i_accept (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm),
      .clear_i     (clear),
      .sample_en_i (sample_en),
      .req_n_i     (req_n),
      .take_i      (take),
      .held_o      (held),
      .open_o      (win_open)
   );

   dreq_seq_ctrl #(
      .CW  (CW),
      .DW  (DW),
      .GAP (GAP)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (cfg_we),
      .cfg_en_i    (cfg_en),
      .cfg_count_i (cfg_count),
      .held_i      (held),
      .bus_free_i  (bus_free),
      .m_ack_i     (m_ack),
      .m_rdata_i   (m_rdata),
      .state_o     (state),
      .chan_en_o   (chan_en),
      .done_o      (done),
      .busy_o      (busy),
      .cfg_load_o  (cfg_load),
      .arm_o       (arm),
      .clear_o     (clear),
      .take_o      (take),
      .adv_o       (adv),
      .data_o      (data)
   );

   assign base_addr[PORT_SRC] = cfg_src;
   assign base_addr[PORT_DST] = cfg_dst;
   assign base_inc[PORT_SRC]  = cfg_src_inc;
   assign base_inc[PORT_DST]  = cfg_dst_inc;

   generate
      for (genvar g = 0; g < N_PORTS; g++) begin : g_addr
         dreq_addr_step #(
            .AW   (AW),
            .STEP (STEP)
         ) i_step (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (cfg_load),
            .load_addr_i (base_addr[g]),
            .load_inc_i  (base_inc[g]),
            .adv_i       (adv),
            .addr_o      (cur_addr[g])
         );
      end
   endgenerate

   assign m_valid = (state == SEQ_READ) || (state == SEQ_WRITE);
   assign m_write = (state == SEQ_WRITE);
   assign m_addr  = m_write ? cur_addr[PORT_DST] : cur_addr[PORT_SRC];
   assign m_wdata = data;

   logic unused_open;
   assign unused_open = win_open;

endmodule

// File: rtl/dreq_level_seq_chk.sv
// Protocol checker bound to the sequencer top.
module dreq_level_seq_chk #(
   parameter int unsigned AW  = 16,
   parameter int unsigned DW  = 16,
   parameter int unsigned CW  = 8,
   parameter int unsigned GAP = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic          m_valid,
   input logic          m_write,
   input logic [AW-1:0] m_addr,
   input logic          m_ack,
   input logic          busy,
   input logic          done
);

   // R5: an unacknowledged cycle keeps its type and address
   p_hold_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ack) |=> (m_valid && $stable(m_write) && $stable(m_addr)));

   // R5: an acknowledged read is followed at once by the write
   p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_write && m_ack) |=> (m_valid && m_write));

   // R6: an acknowledged write ends the activation
   p_write_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_ack) |=> !m_valid);

   // R4: a read start is preceded by at least two busy cycles
   p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_valid) |-> ($past(busy, 1) && $past(busy, 2) && !m_write));

   // R8: a finished channel shows no activity
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!m_valid && !busy));

   // R11: a bus cycle implies the block reports busy
   p_valid_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> busy);

   // R11: a configuration write while busy leaves the activation running
   p_cfg_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && m_valid && !m_ack) |=> m_valid);

endmodule

bind dreq_level_seq dreq_level_seq_chk #(
   .AW  (AW),
   .DW  (DW),
   .CW  (CW),
   .GAP (GAP)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_we  (cfg_we),
   .m_valid (m_valid),
   .m_write (m_write),
   .m_addr  (m_addr),
   .m_ack   (m_ack),
   .busy    (busy),
   .done    (done)
);

// File: tb/test_dreq_level_seq.sv
module test_dreq_level_seq;

   localparam int unsigned AW  = 16;
   localparam int unsigned DW  = 16;
   localparam int unsigned CW  = 8;
   localparam int unsigned GAP = 3;
   localparam int unsigned STEP = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_en = 1'b0;
   logic          cfg_level = 1'b0;
   logic          cfg_src_inc = 1'b0;
   logic          cfg_dst_inc = 1'b0;
   logic [AW-1:0] cfg_src = '0;
   logic [AW-1:0] cfg_dst = '0;
   logic [CW-1:0] cfg_count = '0;
   logic          req_n = 1'b1;
   logic          bus_free = 1'b1;
   logic          m_valid;
   logic          m_write;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic [DW-1:0] m_rdata;
   logic          m_ack = 1'b0;
   logic          busy;
   logic          done;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  rnd_mode = 1'b0;
   bit  strict = 1'b0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   dreq_level_seq #(.AW(AW), .DW(DW), .CW(CW), .GAP(GAP)) i_dreq_level_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
      .cfg_level(cfg_level), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
      .req_n(req_n), .bus_free(bus_free), .m_valid(m_valid), .m_write(m_write),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
      .busy(busy), .done(done)
   );

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5A3C;
   endfunction

   assign m_rdata = mem_word(m_addr);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   // Slave side: acknowledge and bus-free, driven between edges.
   always @(negedge clk) begin
      m_ack <= m_valid && (!rnd_mode || ($urandom % 3 == 0));
      if (rnd_mode) bus_free <= ($urandom % 2 == 0);
   end

   // Monitor: runs just after each rising edge, builds expectations.
   int            cyc = 0;
   int            last_evt = 0;
   int            pairs = 0;
   int            left = 0;
   bit            active = 1'b0;
   bit            e_sinc = 1'b0, e_dinc = 1'b0;
   logic [AW-1:0] e_src = '0, e_dst = '0;
   bit            p_valid = 1'b0, p_write = 1'b0, p_busy = 1'b0;

   always @(posedge clk) begin
      #1;
      if (!rst_n) begin
         p_valid = 1'b0; p_write = 1'b0; p_busy = 1'b0;
      end else begin
         cyc++;
         if (cfg_we && !p_busy) begin
            active = cfg_en && cfg_level && (cfg_count != 0);
            left   = cfg_en ? int'(cfg_count) : 0;
            e_src  = cfg_src; e_dst = cfg_dst;
            e_sinc = cfg_src_inc; e_dinc = cfg_dst_inc;
            last_evt = cyc;
         end
         if (p_valid && p_write && m_ack) begin
            pairs++;
            left--;
            if (e_sinc) e_src = e_src + AW'(STEP);
            if (e_dinc) e_dst = e_dst + AW'(STEP);
            if (left == 0) active = 1'b0;
            last_evt = cyc;
         end
         if (m_valid && !m_write && !(p_valid && !p_write)) begin
            chk(active, "R7/R8 read only on a live channel", 1, active);
            chk(m_addr == e_src, "R10 read address", m_addr, e_src);
            chk(cyc - last_evt >= GAP + 1, "R4 minimum start distance", cyc - last_evt, GAP + 1);
            if (strict)
               chk(cyc - last_evt == GAP + 1, "R6 back-to-back start", cyc - last_evt, GAP + 1);
         end
         if (m_valid && m_write && !(p_valid && p_write)) begin
            chk(p_valid && !p_write, "R5 write follows read", p_valid, 1);
            chk(m_addr == e_dst, "R10 write address", m_addr, e_dst);
            chk(m_wdata == mem_word(e_src), "R5 write data", m_wdata, mem_word(e_src));
         end
         p_valid = m_valid; p_write = m_write; p_busy = busy;
      end
   end

   // Watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         report();
      end
   end

   task automatic do_cfg(input bit en, input bit lvl, input logic [AW-1:0] s,
                         input logic [AW-1:0] d, input int cnt, input bit si, input bit di);
      cfg_en = en; cfg_level = lvl; cfg_src = s; cfg_dst = d;
      cfg_count = CW'(cnt); cfg_src_inc = si; cfg_dst_inc = di;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_done(input int lim);
      for (int i = 0; i < lim && !done; i++) @(negedge clk);
   endtask

   initial begin
      int base;
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!m_valid && !busy && !done, "R12 reset outputs", {m_valid, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: low only during the enabling write cycle
      req_n = 1'b0;
      do_cfg(1, 1, 16'h1000, 16'h2000, 4, 1, 1);
      req_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(pairs == 0 && !busy, "R1 no sampling during enable write", pairs, 0);

      // R2: one-edge low pulse
      base = pairs;
      req_n = 1'b0; @(negedge clk); req_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(pairs - base == 1, "R2 single pulse captured", pairs - base, 1);

      // R3: lows while the window is closed are dropped
      base = pairs;
      req_n = 1'b0; @(negedge clk); req_n = 1'b1;
      for (int i = 0; i < 20 && !m_valid; i++) @(negedge clk);
      req_n = 1'b0; @(negedge clk); req_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(pairs - base == 1, "R3 closed window ignores pin", pairs - base, 1);
      chk(!done, "R8 count not yet exhausted", done, 0);

      // R4: held request waits for the bus
      base = pairs;
      bus_free = 1'b0;
      req_n = 1'b0; @(negedge clk); req_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(busy && !m_valid, "R4 held while bus not free", {busy, m_valid}, 2'b10);
      bus_free = 1'b1;
      repeat (GAP - 1) @(negedge clk);
      chk(!m_valid, "R4 read not before GAP-1 edges", m_valid, 0);
      @(negedge clk);
      chk(m_valid && !m_write, "R4 read at GAP-1 edges after activation", m_valid, 1);
      repeat (10) @(negedge clk);
      chk(pairs - base == 1, "R4 one pair", pairs - base, 1);

      // R6/R8/R10: request held low, exact pacing, count exhaustion
      base = pairs;
      strict = 1'b1;
      req_n = 1'b0;
      do_cfg(1, 1, 16'h3000, 16'h4400, 5, 1, 0);
      wait_done(200);
      strict = 1'b0;
      chk(done, "R8 done after last unit", done, 1);
      chk(pairs - base == 5, "R6 one pair per window", pairs - base, 5);
      repeat (20) @(negedge clk);
      chk(pairs - base == 5 && !busy, "R8 pin ignored after done", pairs - base, 5);

      // R8 clear, R9 zero count
      do_cfg(0, 1, 16'h0, 16'h0, 3, 0, 0);
      chk(!done, "R8 disable write clears done", done, 1'b0);
      do_cfg(1, 1, 16'h5000, 16'h6000, 0, 1, 1);
      chk(done, "R9 zero count sets done", done, 1);
      base = pairs;
      repeat (15) @(negedge clk);
      chk(pairs == base && !busy, "R9 no cycle for zero count", pairs - base, 0);

      // R7: level bit off
      do_cfg(1, 0, 16'h5000, 16'h6000, 3, 1, 1);
      repeat (20) @(negedge clk);
      chk(pairs == base && !busy && !done, "R7 pin ignored without level bit", pairs - base, 0);

      // R11: configuration write during a transfer is ignored
      base = pairs;
      do_cfg(1, 1, 16'h7000, 16'h7800, 3, 1, 1);
      for (int i = 0; i < 20 && !m_valid; i++) @(negedge clk);
      do_cfg(0, 0, 16'h0, 16'h0, 0, 0, 0);
      wait_done(200);
      chk(done && pairs - base == 3, "R11 write while busy ignored", pairs - base, 3);

      // Randomized rounds: backpressure, bus gaps, random pin
      rnd_mode = 1'b1;
      for (int r = 0; r < 10; r++) begin
         int cnt;
         cnt = 2 + int'($urandom % 8);
         base = pairs;
         req_n = 1'b1;
         do_cfg(1, 1, AW'($urandom), AW'($urandom), cnt, $urandom % 2 == 0, $urandom % 2 == 0);
         for (int i = 0; i < 3000 && !done; i++) begin
            req_n = ($urandom % 2 == 0);
            @(negedge clk);
         end
         chk(done, "R8 random round done", done, 1);
         chk(pairs - base == cnt, "R2 random round unit count", pairs - base, cnt);
      end
      rnd_mode = 1'b0;
      req_n = 1'b1;
      repeat (5) @(negedge clk);
      report();
   end

endmodule